// File: doc/BRIEF.md
# Frame Gap Countdown Timer

The block measures the quiet interval a transmitter must leave between two frames, counted in bit times. Software writes an 8-bit gap value; the block keeps half of it in a 7-bit register. A start pulse copies that half into a down-counter and begins the first of two equal countdowns. The counter steps once per bit-time tick. When the second countdown reaches zero the block drops busy and raises done for one clock, so the total gap is twice the halved value. Only even gaps can be made. A stored half of zero stands for 128, which makes a written 0 or 1 give 256 bit times.

A status byte can be read at any time, with no handshake. Bit 7 is 1 while the first countdown runs and 0 otherwise. Bits 6:0 show the live count. The reader is not synchronised to the counter, so the byte reflects whatever cycle it is sampled in. A write while a gap is being timed changes only the stored half. That value is used at the next start.

Top module: `frame_gap_timer`

## Requirements
- R1: After reset busy is 0, done is 0 and the status byte is 0x00.
- R2: A write stores bits 7:1 of the written byte as the half value; the next gap lasts 2*half ticks, so an odd value V gives V-1 ticks.
- R3: The count changes only on a clock in which bit_tick is 1 while busy, or in which start is 1.
- R4: Status bit 7 is 1 throughout the first countdown and 0 during the second and when idle; bits 6:0 show the current count, which equals the half value right after start and again right after the first countdown ends.
- R5: A stored half of zero (written value 0 or 1) gives a gap of 256 ticks.
- R6: start reloads the count from the stored half and begins the first countdown, also when a gap is already running (restart).
- R7: On the clock after the final tick, busy is 0 and done is 1 for exactly one clock; the status byte is then 0x00.
- R8: A write during a gap leaves the running count and the length of both halves unchanged; the new value applies from the next start.
- R9: When start and bit_tick are 1 in the same clock, the start wins and the tick is not counted.
- R10: bit_tick while idle has no effect on busy, done or the status byte.
- R11: When wr_en and start are 1 in the same clock, the start loads the previously stored half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the gap value |
| wr_data | input | 8 | Gap value in bit times |
| bit_tick | input | 1 | One-clock pulse per bit time |
| start | input | 1 | Begin timing a gap |
| busy | output | 1 | A gap is being timed |
| done | output | 1 | One-clock pulse when the gap has elapsed |
| rd_status | output | 8 | {first-half flag, current count} |

## Verification
Two pairs of functions can act in the same clock. A start can land on the same clock as a write, and a start can land on the same clock as a bit tick. The bench sets up each pair deliberately, both while idle and in the middle of a running gap. A behavioural model of the remaining ticks then decides the outcome. That model keeps one remaining-tick count and the value last written, and it must agree with busy, done and the status byte on every clock. The model reproduces the status byte only if the start loaded the old half and the simultaneous tick was dropped.

// File: rtl/frame_gap_pkg.sv
package frame_gap_pkg;
  // Width of the software-written gap value.
  parameter int VAL_W  = 8;
  // Width of the halved countdown value.
  localparam int HALF_W = VAL_W - 1;

  typedef logic [VAL_W-1:0]  gap_val_t;
  typedef logic [HALF_W-1:0] half_val_t;

  // Halve a written gap value (only even gaps exist).
  function automatic half_val_t halve_gap(input gap_val_t v);
    return v[VAL_W-1:1];
  endfunction

  // Ticks one countdown takes for a stored half value; zero means full range.
  function automatic int unsigned half_ticks(input half_val_t h);
    return (h == '0) ? (1 << HALF_W) : int'(h);
  endfunction

  // Whole-gap length in ticks.
  function automatic int unsigned gap_ticks(input half_val_t h);
    return 2 * half_ticks(h);
  endfunction
endpackage

// File: rtl/gap_value_reg.sv
module gap_value_reg
  import frame_gap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  gap_val_t  wr_data,
  output half_val_t stored_half
);
  half_val_t half_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      half_q <= '0;
    else if (wr_en)  half_q <= halve_gap(wr_data);
  end

  assign stored_half = half_q;

  // R2
  store_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stored_half == $past(wr_data[VAL_W-1:1])));
endmodule

// File: rtl/gap_down_counter.sv
module gap_down_counter
  import frame_gap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,       // start: capture stored half and load
  input  logic      tick_en,    // qualified tick
  input  logic      first_half, // current phase
  input  half_val_t load_half,
  output half_val_t count,
  output logic      half_end    // tick that takes count from 1 to 0
);
  half_val_t count_q;
  half_val_t active_q;  // half used for the running gap

  localparam half_val_t ONE = half_val_t'(1);

  assign half_end = tick_en && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      active_q <= '0;
    end else if (load) begin
      count_q  <= load_half;
      active_q <= load_half;
    end else if (half_end && first_half) begin
      count_q  <= active_q;
    end else if (tick_en) begin
      count_q  <= count_q - ONE;
    end
  end

  assign count = count_q;

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_half)));
endmodule

// File: rtl/gap_phase_ctrl.sv
module gap_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic half_end,
  output logic busy,
  output logic first_half,
  output logic done
);
  logic busy_q, first_q, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start) begin
      busy_q  <= 1'b1;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (half_end) begin
      if (first_q) begin
        first_q <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy       = busy_q;
  assign first_half = first_q;
  assign done       = done_q;

  // R4
  phase_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(first_half) |-> $past(half_end));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && first_half));
endmodule

// File: rtl/frame_gap_timer.sv
module frame_gap_timer
  import frame_gap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             bit_tick,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [VAL_W-1:0] rd_status
);
  half_val_t stored_half;
  half_val_t count;
  logic      half_end;
  logic      first_half;
  logic      tick_en;   // tick counted: running and not overridden by start

  assign tick_en = bit_tick && busy && !start;

  gap_value_reg u_value (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .stored_half (stored_half)
  );

  gap_down_counter u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .tick_en    (tick_en),
    .first_half (first_half),
    .load_half  (stored_half),
    .count      (count),
    .half_end   (half_end)
  );

  gap_phase_ctrl u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .half_end   (half_end),
    .busy       (busy),
    .first_half (first_half),
    .done       (done)
  );

  assign rd_status = {first_half, count};

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !start) |=> $stable(rd_status));
  // R10
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: tb/frame_gap_timer_bench.sv
`timescale 1ns/1ps
module frame_gap_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, bit_tick, start;
  logic [7:0] wr_data;
  logic       busy, done;
  logic [7:0] rd_status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural model
  int m_written = 0;  // last written byte
  int m_rem     = 0;  // ticks left in the gap
  int m_hn      = 128; // ticks per half for the running gap
  bit m_done    = 1'b0;

  always #5 clk = ~clk;

  frame_gap_timer u_frame_gap_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_tick(bit_tick), .start(start), .busy(busy), .done(done),
    .rd_status(rd_status)
  );

  function automatic logic [7:0] exp_status();
    int c;
    if (m_rem == 0) return 8'h00;
    if (m_rem > m_hn) begin
      c = (m_rem - m_hn) % 128;
      return {1'b1, 7'(c)};
    end
    c = m_rem % 128;
    return {1'b0, 7'(c)};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "busy", int'(busy), int'(m_rem > 0));
    chk(tag, "done", int'(done), int'(m_done));
    chk(tag, "status", int'(rd_status), int'(exp_status()));
  endtask

  task automatic model_step(input bit wr, input int d, input bit tk, input bit st);
    int h;
    if (st) begin
      h = m_written / 2;
      m_hn = (h == 0) ? 128 : h;
      m_rem = 2 * m_hn;
      m_done = 1'b0;
    end else if (tk && m_rem > 0) begin
      m_rem--;
      m_done = (m_rem == 0);
    end else begin
      m_done = 1'b0;
    end
    if (wr) m_written = d;
  endtask

  task automatic cyc(input bit wr, input int d, input bit tk, input bit st, input string tag);
    wr_en = wr; wr_data = 8'(d); bit_tick = tk; start = st;
    @(posedge clk);
    model_step(wr, d, tk, st);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, 1'b0, tag);
  endtask

  // tick n times, with a quiet clock after every tick when sparse is set
  task automatic ticks(input int n, input bit sparse, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 0, 1'b1, 1'b0, tag);
      if (sparse) cyc(1'b0, 0, 1'b0, 1'b0, tag);
    end
  endtask

  task automatic expect_gap(input int wr_val, input int n, input string tag);
    cyc(1'b1, wr_val, 1'b0, 1'b0, tag);
    cyc(1'b0, 0, 1'b0, 1'b1, tag);
    ticks(n - 1, 1'b0, tag);
    chk(tag, "busy before last tick", int'(busy), 1);
    cyc(1'b0, 0, 1'b1, 1'b0, tag);
    chk(tag, "done at end", int'(done), 1);
    idle(1, tag);
    chk(tag, "done dropped", int'(done), 0);
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; bit_tick = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    compare("R1");
    chk("R1", "status after reset", int'(rd_status), 0);

    // R2 R4 R7: even value, dense and sparse ticks
    cyc(1'b1, 8, 1'b0, 1'b0, "R2");
    cyc(1'b0, 0, 1'b0, 1'b1, "R4");
    chk("R4", "first half flag and count", int'(rd_status), 8'h84);
    ticks(4, 1'b1, "R3");
    chk("R4", "second half reloaded", int'(rd_status), 8'h04);
    ticks(4, 1'b0, "R7");
    chk("R7", "done pulse", int'(done), 1);
    chk("R7", "status idle", int'(rd_status), 0);
    idle(2, "R7");

    // R2: odd value loses its low bit
    expect_gap(5, 4, "R2");
    expect_gap(254, 254, "R2");
    // R5: zero and one mean 256
    expect_gap(0, 256, "R5");
    expect_gap(1, 256, "R5");

    // R10: ticks while idle
    ticks(5, 1'b0, "R10");
    chk("R10", "idle status", int'(rd_status), 0);

    // R8: write mid-gap does not disturb running gap
    cyc(1'b1, 6, 1'b0, 1'b0, "R8");
    cyc(1'b0, 0, 1'b0, 1'b1, "R8");
    ticks(2, 1'b0, "R8");
    cyc(1'b1, 20, 1'b0, 1'b0, "R8");
    ticks(1, 1'b0, "R8");
    chk("R8", "second half uses old value", int'(rd_status), 8'h03);
    ticks(2, 1'b0, "R8");
    cyc(1'b1, 40, 1'b1, 1'b0, "R8");
    chk("R8", "gap ended on old length", int'(done), 1);
    // next start uses the latest write (40)
    cyc(1'b0, 0, 1'b0, 1'b1, "R8");
    chk("R8", "new value at start", int'(rd_status), 8'h94);

    // R6: restart in mid gap
    ticks(7, 1'b0, "R6");
    cyc(1'b0, 0, 1'b0, 1'b1, "R6");
    chk("R6", "restart reload", int'(rd_status), 8'h94);

    // R9: start and tick together, running and idle
    cyc(1'b0, 0, 1'b1, 1'b1, "R9");
    chk("R9", "tick dropped on start", int'(rd_status), 8'h94);
    ticks(40, 1'b0, "R9");
    idle(1, "R9");
    cyc(1'b0, 0, 1'b1, 1'b1, "R9");
    chk("R9", "idle start with tick", int'(rd_status), 8'h94);

    // R11: write and start together, running and idle
    cyc(1'b1, 10, 1'b0, 1'b1, "R11");
    chk("R11", "old half loaded", int'(rd_status), 8'h94);
    ticks(40, 1'b0, "R11");
    cyc(1'b1, 2, 1'b0, 1'b1, "R11");
    chk("R11", "previous write loaded", int'(rd_status), 8'h85);
    ticks(10, 1'b1, "R11");
    idle(2, "R11");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule